// File: doc/BRIEF.md
# Coin-Accepting Vending Controller

This block is a clocked controller for a candy dispenser that takes nickels and dimes. Each coin is seen as a level: its input goes high when the coin arrives and stays high while the coin is in the sensor. The controller adds the value of each coin once, on the rising level. When the running total reaches 15 cents or more, it raises a release flag. The flag stays high until the coin that completed the payment is withdrawn. The controller then goes back to zero credit. A total of 20 cents gets the same release and no change.

Both coin inputs pass through a synchronizer chain of `SYNC_STAGES` flops before the state machine uses them. The state machine has six states: idle, a nickel present with 5 cents, a coin present with 10 cents, 5 cents waiting, 10 cents waiting, and paid. A sample with both coin inputs high is illegal. On such a sample the machine keeps its state and sets a fault flag, which only reset clears.

Top module: `coin_vend_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `release_o` and `fault_o` are 0 and the credit is zero.
- R2: A nickel adds 5 cents and a dime adds 10 cents. `release_o` is 1 while the coin that brings the total to 15 or 20 cents is held, for every order of nickels and dimes.
- R3: A coin counts exactly once however long it is held. The next coin counts only after both inputs have been low.
- R4: After a release, `release_o` returns to 0 once both coin inputs are low, and the credit restarts from zero.
- R5: With `SYNC_STAGES`=2, `release_o` rises on the third rising clock edge after the completing coin input rises. It falls on the third rising edge after that input falls.
- R6: A synchronized sample with both coin inputs high leaves the state unchanged and sets `fault_o`. `fault_o` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dime_in | input | 1 | High while a dime is present |
| nickel_in | input | 1 | High while a nickel is present |
| release_o | output | 1 | High while the machine is in the paid state |
| fault_o | output | 1 | Sticky flag: both coins were seen high at once |

## Verification
An input change reaches `release_o` after three rising edges: two synchronizer flops and the state register. The bench drives inputs on falling edges. For steady-state results it holds each level for four full cycles before it samples on a falling edge. The latency check samples on the falling edge after the second rising edge, where the old value is expected, and again after the third, where the new value is expected. The fault flag and the held state are checked four cycles after the illegal input. The held state is checked through the release that the next coin produces.

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dime_in,
  input  logic nickel_in,
  output logic release_o,
  output logic fault_o
);

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_NICK5  = 3'd1,
    ST_HELD10 = 3'd2,
    ST_WAIT5  = 3'd3,
    ST_WAIT10 = 3'd4,
    ST_PAID   = 3'd5
  } vend_st_t;

  logic [SYNC_STAGES-1:0] dime_sh, nick_sh;
  logic dime_s, nick_s, both_s;
  vend_st_t state, state_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      dime_sh <= '0;
      nick_sh <= '0;
    end else begin
      dime_sh <= {dime_sh[SYNC_STAGES-2:0], dime_in};
      nick_sh <= {nick_sh[SYNC_STAGES-2:0], nickel_in};
    end
  end

  assign dime_s = dime_sh[SYNC_STAGES-1];
  assign nick_s = nick_sh[SYNC_STAGES-1];
  assign both_s = dime_s & nick_s;

  always_comb begin
    state_nx = state;
    if (!both_s) begin
      case (state)
        ST_IDLE:   if (nick_s) state_nx = ST_NICK5;
                   else if (dime_s) state_nx = ST_HELD10;
        ST_NICK5:  if (!nick_s && !dime_s) state_nx = ST_WAIT5;
        ST_HELD10: if (!nick_s && !dime_s) state_nx = ST_WAIT10;
        ST_WAIT5:  if (nick_s) state_nx = ST_HELD10;
                   else if (dime_s) state_nx = ST_PAID;
        ST_WAIT10: if (nick_s || dime_s) state_nx = ST_PAID;
        ST_PAID:   if (!nick_s && !dime_s) state_nx = ST_IDLE;
        default:   state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      fault_o <= 1'b0;
    end else begin
      state <= state_nx;
      if (both_s) fault_o <= 1'b1;
    end
  end

  assign release_o = (state == ST_PAID);

endmodule

// File: rtl/coin_vend_ctrl_chk.sv
module coin_vend_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       dime_s,
  input logic       nick_s,
  input logic [2:0] state,
  input logic       release_o,
  input logic       fault_o
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!release_o && !fault_o));

  assert_release_on_coin_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(release_o) |-> $past(dime_s || nick_s));

  assert_release_held_R4: assert property (@(posedge clk) disable iff (rst)
    (release_o && (dime_s || nick_s)) |=> release_o);

  assert_release_drop_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(release_o) |-> $past(!dime_s && !nick_s));

  assert_both_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (dime_s && nick_s) |=> $stable(state));

  assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    fault_o |=> fault_o);

endmodule

bind coin_vend_ctrl coin_vend_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .dime_s(dime_s), .nick_s(nick_s),
  .state(state), .release_o(release_o), .fault_o(fault_o)
);

// File: tb/test_coin_vend_ctrl.sv
module test_coin_vend_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dime_in = 1'b0;
  logic nickel_in = 1'b0;
  logic release_o, fault_o;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coin_vend_ctrl i_coin_vend_ctrl (
    .clk(clk), .rst(rst), .dime_in(dime_in), .nickel_in(nickel_in),
    .release_o(release_o), .fault_o(fault_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic drive(input logic d, input logic n, input int cycles);
    @(negedge clk);
    dime_in = d;
    nickel_in = n;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; dime_in = 1'b0; nickel_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int credit;
    do_reset();
    chk("R1 release after reset", release_o, 1'b0);
    chk("R1 fault after reset", fault_o, 1'b0);

    for (int len = 1; len <= 3; len++) begin
      for (int code = 0; code < (1 << len); code++) begin
        do_reset();
        credit = 0;
        for (int i = 0; i < len; i++) begin
          logic isd;
          isd = code[i];
          drive(isd, ~isd, 4);
          credit += isd ? 10 : 5;
          chk(credit == 20 ? "R2 twenty cents" : "R2 coin held", release_o, credit >= 15);
          drive(1'b0, 1'b0, 4);
          chk("R4 after withdraw", release_o, 1'b0);
          if (credit >= 15) credit = 0;
        end
      end
    end

    do_reset();
    drive(1'b0, 1'b1, 30);
    chk("R3 long nickel one", release_o, 1'b0);
    drive(1'b0, 1'b0, 4);
    drive(1'b0, 1'b1, 30);
    chk("R3 long nickel two", release_o, 1'b0);
    drive(1'b0, 1'b0, 4);
    drive(1'b0, 1'b1, 4);
    chk("R3 third nickel pays", release_o, 1'b1);
    drive(1'b0, 1'b0, 4);
    drive(1'b1, 1'b0, 4);
    chk("R4 fresh credit after pay", release_o, 1'b0);

    do_reset();
    drive(1'b0, 1'b1, 4);
    drive(1'b0, 1'b0, 4);
    @(negedge clk); dime_in = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R5 rise not before third edge", release_o, 1'b0);
    @(negedge clk);
    chk("R5 rise at third edge", release_o, 1'b1);
    repeat (2) @(negedge clk);
    dime_in = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R5 fall not before third edge", release_o, 1'b1);
    @(negedge clk);
    chk("R5 fall at third edge", release_o, 1'b0);

    do_reset();
    drive(1'b0, 1'b1, 4);
    drive(1'b0, 1'b0, 4);
    drive(1'b1, 1'b1, 4);
    chk("R6 fault set", fault_o, 1'b1);
    chk("R6 no release on both", release_o, 1'b0);
    drive(1'b0, 1'b0, 4);
    drive(1'b1, 1'b0, 4);
    chk("R6 state held, dime pays", release_o, 1'b1);
    drive(1'b0, 1'b0, 4);
    chk("R6 fault sticky", fault_o, 1'b1);
    do_reset();
    chk("R1 fault cleared by reset", fault_o, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule